// File: doc/BRIEF.md
# Serial Video Word Transmitter

This block takes 10-bit parallel video words and sends them as one serial bit stream clocked at ten times the word rate. A divide-by-ten counter inside the block makes the word-load strobe. The strobe goes out on a port so that the word source knows when its word has been taken. Each captured word is shifted out least significant bit first.

Every serial bit passes through a self-synchronising scrambler built on x^9 + x^4 + 1. The scrambled stream is then NRZI-coded, so a scrambled one becomes a level change on the line. The line is driven as a true and a complement pair. Both lines are held low while the external lock indication is low, so that no data leaves the block before the serial clock is trusted.

The analog clock multiplier and the line driver are outside this block. The block runs entirely on the serial-rate clock.

Top module: `serial_word_tx`

## Requirements
- R1: `word_take` is high for exactly one clock in every ten. After a synchronous reset it first rises in the 10th clock cycle, when the internal counter reaches 9.
- R2: On the rising clock edge where `word_take` is high, `word_in` is captured. Its bits are then sent one per clock, bit 0 first and bit 9 last. The shift register holds zeros after reset.
- R3: Each scrambled bit equals the serial data bit XOR the scrambled bit from 4 clocks earlier XOR the scrambled bit from 9 clocks earlier (x^9 + x^4 + 1).
- R4: The NRZI line level inverts on the clock edge that follows a scrambled 1 and stays the same after a scrambled 0.
- R5: While `lock_ok` is low, `sdo_p` and `sdo_n` are both 0.
- R6: While `lock_ok` is high, `sdo_n` is the inverse of `sdo_p`.
- R7: A synchronous active-low reset clears the counter, the scrambler history and the NRZI level to zero. After reset with lock high, `sdo_p`=0 and `sdo_n`=1.
- R8: After reset, words of value 0x000 keep the scrambler in its all-zero state, so `sdo_p` stays 0 until a nonzero word begins to shift out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 10 | Parallel word, captured when `word_take` is high |
| lock_ok | input | 1 | Lock indication; low mutes both outputs |
| word_take | output | 1 | Load strobe, high one clock in ten |
| sdo_p | output | 1 | Serial NRZI data, true |
| sdo_n | output | 1 | Serial NRZI data, complement |

## Verification
The bench builds the block with its default parameters: 10-bit words and scrambler taps at 4 and 9. This small configuration allows every one of the 1024 possible word values to be sent through the full encoder in a single run. The bench recovers each word with its own NRZI decoder and descrambler, and compares it with the word that was driven when the strobe was seen. The run starts with zero and all-ones words and ends with alternating patterns. It also checks the strobe phase on every cycle, the output muting and the complement relation.

// File: rtl/ser_pkg.sv
// Shared sizing for the serial word transmitter.
package ser_pkg;
    parameter int unsigned SER_WORD_W = 10; // bits per parallel word
    parameter int unsigned SER_TAP_LO = 4;  // short scrambler delay
    parameter int unsigned SER_TAP_HI = 9;  // long scrambler delay
endpackage

// File: rtl/ser_word_counter.sv
// Divide-by-N counter that makes the word-load strobe.
// Assumes N >= 2. The strobe is high while the count sits at N-1.
module ser_word_counter #(
    parameter int unsigned N = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic take
);
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // Count 0..N-1 and wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // The strobe marks the final count of each period.
    always_comb take = (cnt == LAST);

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r7_count_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));
endmodule

// File: rtl/ser_piso.sv
// Parallel-in serial-out register. It loads on `load` and then shifts right,
// so bit 0 leaves first. Zeros are shifted in behind the word.
module ser_piso #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         bit_out
);
    logic [W-1:0] sreg;

    // Capture a new word or advance one bit toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n)    sreg <= '0;
        else if (load) sreg <= word;
        else           sreg <= {1'b0, sreg[W-1:1]};
    end

    // The current serial bit is the low end of the register.
    always_comb bit_out = sreg[0];

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sreg == $past(word)));
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (sreg[W-2:0] == $past(sreg[W-1:1])));
endmodule

// File: rtl/ser_scrambler.sv
// Self-synchronising scrambler: out = in ^ out[-LO] ^ out[-HI].
// Assumes 1 <= LO < HI. The history holds past scrambled bits, newest in bit 0.
module ser_scrambler #(
    parameter int unsigned LO = 4,
    parameter int unsigned HI = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sout
);
    logic [HI-1:0] hist;

    // Mix the incoming bit with the two delayed scrambled bits.
    always_comb sout = din ^ hist[LO-1] ^ hist[HI-1];

    // Push each scrambled bit into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HI-2:0], sout};
    end

    a_r3_history_feed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hist[0] == $past(sout)));
    a_r7_history_clear: assert property (@(posedge clk)
        !rst_n |=> (hist == '0));
endmodule

// File: rtl/ser_nrzi.sv
// NRZI encoder: the line level inverts after each 1 and holds after each 0.
module ser_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic sin,
    output logic level
);
    // Toggle the held level on a one.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= 1'b0;
        else        level <= level ^ sin;
    end

    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        sin |=> (level != $past(level)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sin |=> $stable(level));
    a_r7_level_clear: assert property (@(posedge clk)
        !rst_n |=> !level);
endmodule

// File: rtl/serial_word_tx.sv
// Serial word transmitter: divide-by-WORD_W load strobe, LSB-first shifter,
// x^HI+x^LO+1 scrambler, NRZI encoder and a lock-gated differential pair.
// Assumes clk runs at WORD_W times the word rate.
module serial_word_tx
    import ser_pkg::*;
#(
    parameter int unsigned WORD_W = SER_WORD_W,
    parameter int unsigned TAP_LO = SER_TAP_LO,
    parameter int unsigned TAP_HI = SER_TAP_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              lock_ok,
    output logic              word_take,
    output logic              sdo_p,
    output logic              sdo_n
);
    logic plain_bit;
    logic scr_bit;
    logic line_lvl;

    ser_word_counter #(.N(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take(word_take)
    );

    ser_piso #(.W(WORD_W)) u_piso (
        .clk(clk), .rst_n(rst_n), .load(word_take), .word(word_in),
        .bit_out(plain_bit)
    );

    ser_scrambler #(.LO(TAP_LO), .HI(TAP_HI)) u_scr (
        .clk(clk), .rst_n(rst_n), .din(plain_bit), .sout(scr_bit)
    );

    ser_nrzi u_nrzi (
        .clk(clk), .rst_n(rst_n), .sin(scr_bit), .level(line_lvl)
    );

    // Drive the pair only while locked; otherwise hold both lines low.
    always_comb begin
        sdo_p = lock_ok & line_lvl;
        sdo_n = lock_ok & ~line_lvl;
    end

    a_r5_muted: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |-> (!sdo_p && !sdo_n));
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> (sdo_p != sdo_n));
endmodule

// File: tb/serial_word_tx_test.sv
`timescale 1ns/1ps
module serial_word_tx_test;
    localparam int NCYC  = 10500;
    localparam int NWORD = 1040;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       lock_ok = 1'b1;
    logic       word_take, sdo_p, sdo_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit       rec_bit  [NCYC];
    bit       rec_take [NCYC];
    bit [9:0] rec_word [NCYC];

    always #10 clk = ~clk;

    serial_word_tx uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .lock_ok(lock_ok),
        .word_take(word_take), .sdo_p(sdo_p), .sdo_n(sdo_n)
    );

    function automatic bit [9:0] pattern(input int k);
        if (k < 4)              return 10'h000;
        else if (k < 8)         return 10'h3FF;
        else if (k < 8 + 1024)  return 10'(k - 8);
        else                    return (k % 2 == 0) ? 10'h2AA : 10'h155;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int        widx;
        bit        prev_lvl;
        bit [8:0]  h;
        bit        zero_ok;
        bit        pair_ok;
        bit        take_ok;
        bit [9:0]  got;

        do_reset();
        // R7: state right after reset
        check(sdo_p == 1'b0 && sdo_n == 1'b1, "R7", {sdo_p, sdo_n}, 2'b01);
        check(word_take == 1'b0, "R1", word_take, 0);

        widx = 0;
        word_in = pattern(0);
        prev_lvl = 1'b0;
        h = '0;
        zero_ok = 1'b1;
        pair_ok = 1'b1;
        for (int m = 0; m < NCYC; m++) begin
            bit s;
            if (m > 0) @(negedge clk);
            s = sdo_p ^ prev_lvl;
            prev_lvl = sdo_p;
            rec_bit[m] = s ^ h[3] ^ h[8];
            h = {h[7:0], s};
            rec_take[m] = word_take;
            rec_word[m] = word_in;
            if (m <= 50 && sdo_p) zero_ok = 1'b0;
            if (sdo_n == sdo_p) pair_ok = 1'b0;
            if (word_take) begin
                widx++;
                // change the word only after the load edge has taken it
                @(posedge clk);
                #1 word_in = pattern(widx < NWORD ? widx : 0);
            end
        end
        // R8: zero words keep the line at 0
        check(zero_ok, "R8", 0, 0);
        // R6: complement while locked
        check(pair_ok, "R6", 0, 0);

        // R1: strobe phase on every recorded cycle
        take_ok = 1'b1;
        for (int m = 0; m < NCYC; m++)
            if (rec_take[m] != ((m % 10) == 9)) take_ok = 1'b0;
        check(take_ok, "R1", 0, 0);

        // R2 R3 R4: each word recovered by NRZI decode and descrambling
        for (int m = 0; m + 11 < NCYC; m++) begin
            if (rec_take[m]) begin
                for (int b = 0; b < 10; b++) got[b] = rec_bit[m + 2 + b];
                check(got == rec_word[m], "R2/R3/R4 word", got, rec_word[m]);
            end
        end

        // R5: muting while the lock indication is low
        @(negedge clk);
        lock_ok = 1'b0;
        for (int i = 0; i < 30; i++) begin
            word_in = 10'(i * 37);
            @(negedge clk);
            check(sdo_p == 1'b0 && sdo_n == 1'b0, "R5", {sdo_p, sdo_n}, 0);
        end
        lock_ok = 1'b1;
        #1;
        check(sdo_n == ~sdo_p, "R6", {sdo_p, sdo_n}, {sdo_p, ~sdo_p});

        // R7: reset again from a busy state
        do_reset();
        check(sdo_p == 1'b0 && sdo_n == 1'b1, "R7", {sdo_p, sdo_n}, 2'b01);
        for (int m = 0; m < 12; m++) begin
            if (m > 0) @(negedge clk);
            check(word_take == ((m % 10) == 9), "R1 after reset", word_take, (m % 10) == 9);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule